// File: doc/BRIEF.md
# Poll-Cycle Frame Timer and Buffer RAM Arbiter

This block keeps the poll-frame timing for one node on a polled serial network and decides who may use the node's shared buffer RAM. Every frame opens with a short dead window and continues with a longer transfer window. The nominal lengths are 4 ms and 28 ms of a 32 ms frame, and both are set as clock-tick counts through parameters. When the network interface is fitted, the frame counter restarts on each external sync pulse. When the interface is absent, the counter runs free. If the interface is fitted but sync pulses stop arriving for more than a frame, a status flag is raised. A one-clock frame interrupt marks each frame start.

The buffer RAM is single-ported and synchronous, with one cycle of read latency. It is split into two halves. The serial engine reads its transmit data from the lower half and writes the data it receives into the upper half. The host writes transmit data and reads received data during the dead window, and the serial engine owns the RAM during the transfer window. Bit 0 of a small host-writable latch selects which side drives the RAM controls. A host request that falls outside its allowed window is held off by keeping its ready signal low, and the request completes at the start of the next dead window.

Top module: `poll_frame_arbiter`

## Requirements
- R1: With `net_present` low, `frame_irq` pulses once every FRAME_TICKS clock cycles. No pulse comes from reset itself, and `net_sync` is ignored in this mode.
- R2: `dead_win` is high in the cycle in which `frame_irq` is high and for the following DEAD_TICKS-1 cycles. It is low for the rest of the frame.
- R3: With `net_present` high, a `net_sync` sampled high on a clock edge restarts the frame. `frame_irq` and `dead_win` are high in the cycle after that edge.
- R4: `frame_irq` never stays high for two cycles in a row. A sync sampled while the frame count is already zero produces no second pulse.
- R5: `host_ready` is high, in the same cycle as `host_req`, only when all three of these hold: `dead_win` is high, `latch_q[0]` is 1, and no sync is being honoured in that cycle. In that cycle the RAM signals carry the host address, data and write enable with `ram_en` high.
- R6: A host request held outside the dead window sees `host_ready` low and `ram_en` low. If the request is held, it completes in the first cycle of the next dead window.
- R7: `eng_gnt` is high with `eng_req` only when `dead_win` is low and `latch_q[0]` is 0. The host and the engine are never granted in the same cycle.
- R8: An engine write goes to RAM address {1, `eng_addr`} (upper half). An engine read uses {0, `eng_addr`} (lower half). Host addresses reach the RAM unchanged.
- R9: With `net_present` high, `sync_lost` rises after FRAME_TICKS+1 edges with no sync sampled. It clears on the edge that samples a sync, or when `net_present` is low.
- R10: `latch_q` resets to 0 and takes `host_latch_wdata` on each edge where `host_latch_we` is high.
- R11: `host_rdata` and `eng_rdata` both present `ram_rdata`. This is the read data returned one cycle after the granted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_present | input | 1 | Network interface fitted |
| net_sync | input | 1 | External poll-cycle start pulse |
| frame_irq | output | 1 | One-cycle frame start pulse |
| dead_win | output | 1 | Dead window active |
| sync_lost | output | 1 | Sync missing for more than a frame |
| host_latch_we | input | 1 | Control latch write strobe |
| host_latch_wdata | input | 4 | Control latch write data |
| latch_q | output | 4 | Control latch contents; bit 0 = 1 selects host |
| host_req | input | 1 | Host RAM access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host RAM address |
| host_wdata | input | DATA_W | Host write data |
| host_ready | output | 1 | Host access accepted this cycle |
| host_rdata | output | DATA_W | Host read data |
| eng_req | input | 1 | Serial engine RAM request |
| eng_we | input | 1 | Engine write (receive) or read (transmit) |
| eng_addr | input | ADDR_W-1 | Engine address within a half |
| eng_wdata | input | DATA_W | Engine write data |
| eng_gnt | output | 1 | Engine access accepted this cycle |
| eng_rdata | output | DATA_W | Engine read data |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data (one cycle latency) |

## Verification
The bench builds the block with FRAME_TICKS = 64 and DEAD_TICKS = 8 in place of the multi-million-tick defaults, with ADDR_W = 6 and DATA_W = 16. With these values, a whole frame, a held-off host request that has to wait through most of a transfer window, and a sync timeout of FRAME_TICKS+1 cycles all fit in a few hundred cycles. The short frame also lets the bench land stimulus on exact frame positions, such as a sync while the count is zero. The 64-word RAM model in the bench is small enough that host writes, engine writes to the upper half and cross reads can all be checked through real data.

// File: rtl/poll_frame_arbiter.sv
module poll_frame_arbiter #(
  parameter int FRAME_TICKS = 8000000,
  parameter int DEAD_TICKS  = 1000000,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_present,
  input  logic              net_sync,
  output logic              frame_irq,
  output logic              dead_win,
  output logic              sync_lost,
  input  logic              host_latch_we,
  input  logic [3:0]        host_latch_wdata,
  output logic [3:0]        latch_q,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              eng_req,
  input  logic              eng_we,
  input  logic [ADDR_W-2:0] eng_addr,
  input  logic [DATA_W-1:0] eng_wdata,
  output logic              eng_gnt,
  output logic [DATA_W-1:0] eng_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);

  localparam int CW = $clog2(FRAME_TICKS);
  localparam int MW = $clog2(FRAME_TICKS + 1);

  logic [CW-1:0] cnt;
  logic [MW-1:0] miss;

  wire sync_hit = net_present && net_sync;
  wire wrap     = cnt == CW'(FRAME_TICKS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      frame_irq <= 1'b0;
    end else if (sync_hit || wrap) begin
      cnt       <= '0;
      frame_irq <= cnt != '0;
    end else begin
      cnt       <= cnt + 1'b1;
      frame_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !net_present || net_sync) begin
      miss      <= '0;
      sync_lost <= 1'b0;
    end else begin
      if (miss != MW'(FRAME_TICKS)) miss <= miss + 1'b1;
      else                          sync_lost <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             latch_q <= '0;
    else if (host_latch_we) latch_q <= host_latch_wdata;
  end

  assign dead_win = cnt < CW'(DEAD_TICKS);

  wire host_sel = latch_q[0];
  assign host_ready = host_req && host_sel && dead_win && !sync_hit;
  assign eng_gnt    = eng_req && !host_sel && !dead_win;

  assign ram_en    = host_ready || eng_gnt;
  assign ram_we    = host_ready ? host_we    : (eng_gnt && eng_we);
  assign ram_addr  = host_ready ? host_addr  : {eng_we, eng_addr};
  assign ram_wdata = host_ready ? host_wdata : eng_wdata;

  assign host_rdata = ram_rdata;
  assign eng_rdata  = ram_rdata;

endmodule

// File: rtl/poll_frame_arbiter_chk.sv
module poll_frame_arbiter_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              net_present,
  input logic              net_sync,
  input logic              frame_irq,
  input logic              dead_win,
  input logic              sync_lost,
  input logic              host_latch_we,
  input logic [3:0]        host_latch_wdata,
  input logic [3:0]        latch_q,
  input logic              host_ready,
  input logic              eng_gnt,
  input logic              eng_we,
  input logic              ram_en,
  input logic [ADDR_W-1:0] ram_addr
);

  // R2
  irq_in_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> dead_win);

  // R3
  sync_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (net_present && net_sync) |=> dead_win);

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  // R5
  host_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (dead_win && latch_q[0] && ram_en));

  // R7
  eng_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_gnt |-> (!dead_win && !latch_q[0] && !host_ready));

  // R8
  eng_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_gnt |-> (ram_addr[ADDR_W-1] == eng_we));

  // R9
  lost_needs_net_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> net_present);

  // R10
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_latch_we |=> latch_q == $past(host_latch_wdata));

endmodule

bind poll_frame_arbiter poll_frame_arbiter_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .net_present(net_present), .net_sync(net_sync),
  .frame_irq(frame_irq), .dead_win(dead_win), .sync_lost(sync_lost),
  .host_latch_we(host_latch_we), .host_latch_wdata(host_latch_wdata),
  .latch_q(latch_q), .host_ready(host_ready), .eng_gnt(eng_gnt),
  .eng_we(eng_we), .ram_en(ram_en), .ram_addr(ram_addr)
);

// File: tb/poll_frame_arbiter_tb_top.sv
module poll_frame_arbiter_tb_top;
  localparam int FT = 64;
  localparam int DT = 8;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic net_present = 0, net_sync = 0;
  logic frame_irq, dead_win, sync_lost;
  logic host_latch_we = 0;
  logic [3:0] host_latch_wdata = '0, latch_q;
  logic host_req = 0, host_we = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic host_ready;
  logic eng_req = 0, eng_we = 0;
  logic [AW-2:0] eng_addr = '0;
  logic [DW-1:0] eng_wdata = '0, eng_rdata;
  logic eng_gnt;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic [DW-1:0] mem [2**AW];

  int vectors = 0, errors = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  poll_frame_arbiter #(.FRAME_TICKS(FT), .DEAD_TICKS(DT), .ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_irq();
    int n = 0;
    do begin @(negedge clk); n++; end while (!frame_irq && n < 500);
    if (!frame_irq) chk("R1 wait", 0, 1);
  endtask

  task automatic write_latch(logic [3:0] v);
    @(negedge clk); host_latch_we = 1; host_latch_wdata = v;
    @(negedge clk); host_latch_we = 0;
    chk("R10 latch load", latch_q, v);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset irq", frame_irq, 0);
    chk("R2 reset dead", dead_win, 1);
    chk("R9 reset lost", sync_lost, 0);
    chk("R10 reset latch", latch_q, 0);
  endtask

  task automatic t_period();
    int n = 0, d = 1;
    wait_irq();
    do begin
      @(negedge clk); n++;
      if (!frame_irq && dead_win) d++;
      if (n == 1) chk("R4 irq one cycle", frame_irq, 0);
    end while (!frame_irq && n < 200);
    chk("R1 frame period", n, FT);
    chk("R2 dead length", d, DT);
    net_sync = 1;
    @(negedge clk); net_sync = 0;
    chk("R1 sync ignored when absent", frame_irq, 0);
  endtask

  task automatic t_host();
    write_latch(4'h1);
    wait_irq();
    host_req = 1; host_we = 1; host_addr = 6'd5; host_wdata = 16'h1234; #1;
    chk("R5 host ready in dead", host_ready, 1);
    chk("R5 ram addr", {ram_en, ram_we, ram_addr}, {2'b11, 6'd5});
    @(negedge clk); host_we = 0; #1;
    chk("R5 host read ready", host_ready, 1);
    @(negedge clk); host_req = 0;
    chk("R11 host read data", host_rdata, 16'h1234);
  endtask

  task automatic t_holdoff();
    int n = 0;
    wait_irq();
    repeat (10) @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 6'd9; host_wdata = 16'h5678; #1;
    chk("R6 held off", {host_ready, ram_en}, 2'b00);
    do begin @(negedge clk); #1; n++; end while (!host_ready && n < 200);
    chk("R6 wait length", n, FT - 10);
    chk("R6 completes at frame start", frame_irq, 1);
    @(negedge clk); host_we = 0; #1;
    @(negedge clk); host_req = 0;
    chk("R6 data written", host_rdata, 16'h5678);
  endtask

  task automatic t_engine();
    write_latch(4'hA);
    wait_irq();
    repeat (10) @(negedge clk);
    eng_req = 1; eng_we = 1; eng_addr = 5'd3; eng_wdata = 16'hBEEF; #1;
    chk("R7 engine grant", eng_gnt, 1);
    chk("R8 rx upper half", {ram_we, ram_addr}, {1'b1, 6'd35});
    @(negedge clk); eng_we = 0; eng_addr = 5'd5; #1;
    chk("R8 tx lower half", {ram_we, ram_addr}, {1'b0, 6'd5});
    @(negedge clk); eng_req = 0;
    chk("R11 engine read data", eng_rdata, 16'h1234);
    host_req = 1; host_we = 0; host_addr = 6'd0; #1;
    chk("R5 host denied in transfer", host_ready, 0);
    host_req = 0;
    wait_irq();
    eng_req = 1; host_req = 1; #1;
    chk("R7 engine denied in dead", {eng_gnt, ram_en}, 2'b00);
    chk("R5 host denied when latch selects engine", host_ready, 0);
    eng_req = 0; host_req = 0;
    write_latch(4'h1);
    host_req = 1; host_we = 0; host_addr = 6'd35; #1;
    chk("R5 host ready after latch", host_ready, 1);
    @(negedge clk); host_req = 0;
    chk("R8 host reads rx half", host_rdata, 16'hBEEF);
  endtask

  task automatic t_sync();
    wait_irq();
    repeat (20) @(negedge clk);
    net_present = 1; net_sync = 1;
    @(negedge clk); net_sync = 0;
    chk("R3 sync restarts frame", {frame_irq, dead_win}, 2'b11);
    @(negedge clk);
    chk("R4 irq drops", frame_irq, 0);
    repeat (20) @(negedge clk);
    net_sync = 1;
    @(negedge clk);
    chk("R3 second sync irq", frame_irq, 1);
    @(negedge clk); net_sync = 0;
    chk("R4 no repeat at count zero", {frame_irq, dead_win}, 2'b01);
    net_present = 0;
  endtask

  task automatic t_loss();
    wait_irq();
    repeat (5) @(negedge clk);
    net_present = 1; net_sync = 1;
    @(negedge clk); net_sync = 0;
    for (int k = 1; k <= 65; k++) begin
      @(negedge clk);
      if (k == 64) chk("R9 not lost yet", sync_lost, 0);
      if (k == 65) chk("R9 lost after frame", sync_lost, 1);
    end
    net_sync = 1;
    @(negedge clk); net_sync = 0;
    chk("R9 cleared by sync", sync_lost, 0);
    net_present = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_period();
    t_host();
    t_holdoff();
    t_engine();
    t_sync();
    t_loss();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule